// File: doc/BRIEF.md
# Bit-Aligned Raster Block Transfer Engine

This engine copies a rectangle of pixels, one bit per pixel, from a source area of a word-addressed frame buffer to a destination area. The two areas do not need to share a bit alignment. Each source word is realigned by a left shift of 0 to W-1 bit positions. Bits that spill out of one word are carried into the next word. The aligned word can be inverted. It is then merged with the current destination word by AND, OR, XOR, plain store or a fast OR. Per-word edge masks keep destination bits outside the rectangle unchanged.

A host places the rectangle description on the configuration inputs and pulses `start`. The engine latches the description and runs read-read-write cycles on a single synchronous memory port. It pulses `done` when it finishes, with `err` raised alongside if the request was rejected.

The host chooses the horizontal order, ascending or descending addresses, to make overlapping moves within one scan line safe. The vertical order is set by the signs of the two line pitches. A three-operand effect, such as a stipple pattern, is made by running two two-operand passes in turn.

Top module: `bitblt_engine`

## Requirements
- R1: After reset, and whenever no transfer is running, `busy`, `done`, `err` and `mem_req` are all low.
- R2: `cfg_op` selects how the aligned source S is combined with the destination D. The codes are: 0 gives S AND D, 1 gives S OR D, 2 gives S XOR D, 3 gives S (store), and 4 is a fast OR that gives S OR D.
- R3: Within a line, bits are written only where the mask is 1; all other bits keep their previous destination value.
  - `cfg_mask_first` masks the word at the lowest address.
  - `cfg_mask_last` masks the word at the highest address.
  - When the width is 1, both masks apply.
  - Every other word is written in full.
- R4: The aligned word for source position k of a line is the upper W bits of {src[k], src[k-1]} shifted left by `cfg_shift`. src[-1] is taken as zero at the start of each line.
- R5: When `cfg_inv` is 1, the aligned word is bitwise inverted before it is combined.
- R6: Horizontal order (`cfg_desc`):
  - With `cfg_desc` = 0, the first write of each line goes to its lowest destination address, and writes move upward.
  - With `cfg_desc` = 1, the first write goes to the highest address, dst + width - 1, and writes move downward.
  - Either order produces the same image for non-overlapping areas.
  - A move within one line to a destination to the right of the source produces the correct image in descending order.
- R7: Line n starts at base + n × pitch for both source and destination. Each pitch is a two's-complement value, so a negative pitch walks upward through the buffer.
- R8: The engine rejects a request in either of these cases: the op code is 5, 6 or 7, or the op is the fast OR (4) with `cfg_desc` or `cfg_inv` set. A rejected request pulses `done` together with `err` in the cycle after `start` is accepted, and makes no memory access.
- R9: A height or width of zero pulses `done` with `err` low in the cycle after `start` is accepted, and makes no memory access.
- R10: `done` is high for exactly one cycle per accepted request, and `busy` is high from acceptance until `done`. A `start` that arrives while `busy` is high is ignored.
- R11: Memory port timing:
  - Read data is expected on `mem_rdata` in the cycle after a read request.
  - A write is one cycle with both `mem_req` and `mem_we` high.
  - A successful transfer makes exactly height × width writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; the configuration is latched when it is accepted |
| cfg_src_base | input | AW | Source address of the first line |
| cfg_dst_base | input | AW | Destination address of the first line |
| cfg_src_pitch | input | AW | Signed step between source lines |
| cfg_dst_pitch | input | AW | Signed step between destination lines |
| cfg_shift | input | SW | Left alignment shift, 0 to W-1 |
| cfg_height | input | HW | Number of lines |
| cfg_width | input | WW | Source words per line |
| cfg_mask_first | input | W | Mask for the lowest-address word of a line |
| cfg_mask_last | input | W | Mask for the highest-address word of a line |
| cfg_op | input | 3 | Combine operation code |
| cfg_desc | input | 1 | 1 = descending horizontal order |
| cfg_inv | input | 1 | 1 = invert the aligned source |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid the cycle after a read request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Qualifies `done` when the request was rejected |

## Verification
The bench checks each final image against a model that reads only a snapshot of the initial memory. This catches a design that reads source words after it has already overwritten them. Such a design would corrupt the same-line rightward moves, which are run in descending order. It also catches a wrong shift carry: a design that carries bits from the neighbour on the wrong side, or that fails to clear the carry at a line start, would leak bits between lines.

The bench also exercises:
- width-1 lines, where both masks meet on one word;
- negative pitches;
- shifts of zero and of W-1;
- the rejected mode combinations and zero-sized rectangles, where a careless design would still touch memory;
- a second `start` issued in the middle of a transfer, which a faulty design would accept by restarting or by emitting a second `done`.

// File: rtl/bitblt_pkg.sv
package bitblt_pkg;

  typedef enum logic [2:0] {
    BOP_AND  = 3'd0,
    BOP_OR   = 3'd1,
    BOP_XOR  = 3'd2,
    BOP_COPY = 3'd3,
    BOP_FOR  = 3'd4
  } bop_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRD,
    ST_PCAP,
    ST_SRD,
    ST_DRD,
    ST_WR,
    ST_DONE
  } bst_e;

  // A request is refused for unknown codes, and for the fast OR with any
  // option other than ascending order and true source.
  function automatic logic op_rejected(input logic [2:0] op, input logic desc,
                                       input logic inv);
    return (op > 3'd4) || ((op == BOP_FOR) && (desc || inv));
  endfunction

endpackage

// File: rtl/bitblt_align.sv
module bitblt_align #(
  parameter int W  = 16,
  parameter int SW = 4
) (
  input  logic [W-1:0]  cur,
  input  logic [W-1:0]  carry,
  input  logic [SW-1:0] shift,
  output logic [W-1:0]  aligned
);
  localparam int DW = 2 * W;

  // Upper half of the pair shifted left; shift 0 yields cur unchanged.
  function automatic logic [W-1:0] merge(input logic [W-1:0] hi, input logic [W-1:0] lo,
                                         input logic [SW-1:0] sh);
    logic [DW-1:0] wide;
    wide = {hi, lo} << sh;
    return wide[DW-1:W];
  endfunction

  assign aligned = merge(cur, carry, shift);
endmodule

// File: rtl/bitblt_combine.sv
module bitblt_combine
  import bitblt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic         inv,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] mask,
  output logic [W-1:0] res
);
  function automatic logic [W-1:0] apply_op(input logic [2:0] code, input logic [W-1:0] s,
                                            input logic [W-1:0] d);
    case (code)
      BOP_AND:         return s & d;
      BOP_OR, BOP_FOR: return s | d;
      BOP_XOR:         return s ^ d;
      BOP_COPY:        return s;
      default:         return d;
    endcase
  endfunction

  logic [W-1:0] s_eff;
  logic [W-1:0] f;

  assign s_eff = inv ? ~src : src;
  assign f     = apply_op(op, s_eff, dst);
  assign res   = (f & mask) | (dst & ~mask);
endmodule

// File: rtl/bitblt_seq.sv
module bitblt_seq
  import bitblt_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 16,
  parameter int HW = 8,
  parameter int WW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_src_base,
  input  logic [AW-1:0] cfg_dst_base,
  input  logic [AW-1:0] cfg_src_pitch,
  input  logic [AW-1:0] cfg_dst_pitch,
  input  logic [SW-1:0] cfg_shift,
  input  logic [HW-1:0] cfg_height,
  input  logic [WW-1:0] cfg_width,
  input  logic [W-1:0]  cfg_mask_first,
  input  logic [W-1:0]  cfg_mask_last,
  input  logic [2:0]    cfg_op,
  input  logic          cfg_desc,
  input  logic          cfg_inv,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  input  logic [W-1:0]  mem_rdata,
  output logic [W-1:0]  align_cur,
  output logic [W-1:0]  align_carry,
  output logic [SW-1:0] align_shift,
  input  logic [W-1:0]  aligned,
  output logic [W-1:0]  comb_src,
  output logic [W-1:0]  comb_mask,
  output logic [2:0]    comb_op,
  output logic          comb_inv,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          ev_reject,
  output logic          ev_empty
);
  function automatic logic [AW-1:0] first_ptr(input logic [AW-1:0] base,
                                               input logic [WW-1:0] w, input logic desc);
    return desc ? base + AW'(w) - AW'(1) : base;
  endfunction

  bst_e          st;
  logic [2:0]    op_q;
  logic          desc_q, inv_q, err_q;
  logic [SW-1:0] sh_q;
  logic [WW-1:0] w_q, wcnt;
  logic [HW-1:0] lines_left;
  logic [W-1:0]  mf_q, ml_q, hold, aln_q;
  logic [AW-1:0] sp_q, dp_q, sline, dline, sptr, dptr;

  logic          accept, bad, empty, last, fetch_skip, lo_word, hi_word;
  logic [W-1:0]  src_data;
  logic [AW-1:0] nsline, ndline;

  assign accept     = (st == ST_IDLE) && start;
  assign bad        = op_rejected(cfg_op, cfg_desc, cfg_inv);
  assign empty      = (cfg_height == '0) || (cfg_width == '0);
  assign ev_reject  = accept && bad;
  assign ev_empty   = accept && !bad && empty;

  assign last       = (wcnt == w_q - WW'(1));
  assign fetch_skip = desc_q && last;
  assign src_data   = fetch_skip ? '0 : mem_rdata;

  // Ascending: new word is the current one. Descending: held word is current.
  assign align_cur   = desc_q ? hold : src_data;
  assign align_carry = desc_q ? src_data : hold;
  assign align_shift = sh_q;

  assign lo_word   = desc_q ? last : (wcnt == '0);
  assign hi_word   = desc_q ? (wcnt == '0) : last;
  assign comb_mask = (lo_word ? mf_q : '1) & (hi_word ? ml_q : '1);
  assign comb_src  = aln_q;
  assign comb_op   = op_q;
  assign comb_inv  = inv_q;

  assign nsline = sline + sp_q;
  assign ndline = dline + dp_q;

  assign mem_req  = ((st == ST_SRD) && !fetch_skip) || (st == ST_DRD) ||
                    (st == ST_WR) || (st == ST_PRD);
  assign mem_we   = (st == ST_WR);
  assign mem_addr = ((st == ST_DRD) || (st == ST_WR)) ? dptr : sptr;

  assign busy = (st != ST_IDLE);
  assign done = (st == ST_DONE);
  assign err  = done && err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      op_q       <= '0;
      desc_q     <= 1'b0;
      inv_q      <= 1'b0;
      err_q      <= 1'b0;
      sh_q       <= '0;
      w_q        <= '0;
      wcnt       <= '0;
      lines_left <= '0;
      mf_q       <= '0;
      ml_q       <= '0;
      hold       <= '0;
      aln_q      <= '0;
      sp_q       <= '0;
      dp_q       <= '0;
      sline      <= '0;
      dline      <= '0;
      sptr       <= '0;
      dptr       <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          op_q       <= cfg_op;
          desc_q     <= cfg_desc;
          inv_q      <= cfg_inv;
          sh_q       <= cfg_shift;
          w_q        <= cfg_width;
          mf_q       <= cfg_mask_first;
          ml_q       <= cfg_mask_last;
          sp_q       <= cfg_src_pitch;
          dp_q       <= cfg_dst_pitch;
          sline      <= cfg_src_base;
          dline      <= cfg_dst_base;
          sptr       <= first_ptr(cfg_src_base, cfg_width, cfg_desc);
          dptr       <= first_ptr(cfg_dst_base, cfg_width, cfg_desc);
          lines_left <= cfg_height;
          wcnt       <= '0;
          hold       <= '0;
          err_q      <= bad;
          if (bad || empty) st <= ST_DONE;
          else              st <= cfg_desc ? ST_PRD : ST_SRD;
        end
        ST_PRD: begin
          sptr <= sptr - AW'(1);
          st   <= ST_PCAP;
        end
        ST_PCAP: begin
          hold <= mem_rdata;
          st   <= ST_SRD;
        end
        ST_SRD: begin
          sptr <= desc_q ? sptr - AW'(1) : sptr + AW'(1);
          st   <= ST_DRD;
        end
        ST_DRD: begin
          hold  <= src_data;
          aln_q <= aligned;
          st    <= ST_WR;
        end
        ST_WR: begin
          if (last) begin
            wcnt       <= '0;
            hold       <= '0;
            lines_left <= lines_left - HW'(1);
            sline      <= nsline;
            dline      <= ndline;
            sptr       <= first_ptr(nsline, w_q, desc_q);
            dptr       <= first_ptr(ndline, w_q, desc_q);
            if (lines_left == HW'(1)) st <= ST_DONE;
            else                      st <= desc_q ? ST_PRD : ST_SRD;
          end else begin
            wcnt <= wcnt + WW'(1);
            dptr <= desc_q ? dptr - AW'(1) : dptr + AW'(1);
            st   <= ST_SRD;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitblt_engine.sv
module bitblt_engine #(
  parameter  int W  = 16,
  parameter  int AW = 16,
  parameter  int HW = 8,
  parameter  int WW = 8,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_src_base,
  input  logic [AW-1:0] cfg_dst_base,
  input  logic [AW-1:0] cfg_src_pitch,
  input  logic [AW-1:0] cfg_dst_pitch,
  input  logic [SW-1:0] cfg_shift,
  input  logic [HW-1:0] cfg_height,
  input  logic [WW-1:0] cfg_width,
  input  logic [W-1:0]  cfg_mask_first,
  input  logic [W-1:0]  cfg_mask_last,
  input  logic [2:0]    cfg_op,
  input  logic          cfg_desc,
  input  logic          cfg_inv,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          err
);
  logic [W-1:0]  align_cur, align_carry, aligned, comb_src, comb_mask;
  logic [SW-1:0] align_shift;
  logic [2:0]    comb_op;
  logic          comb_inv;
  logic          ev_reject, ev_empty;

  bitblt_seq #(.W(W), .AW(AW), .HW(HW), .WW(WW), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_src_pitch(cfg_src_pitch), .cfg_dst_pitch(cfg_dst_pitch),
    .cfg_shift(cfg_shift), .cfg_height(cfg_height), .cfg_width(cfg_width),
    .cfg_mask_first(cfg_mask_first), .cfg_mask_last(cfg_mask_last),
    .cfg_op(cfg_op), .cfg_desc(cfg_desc), .cfg_inv(cfg_inv),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .align_cur(align_cur), .align_carry(align_carry), .align_shift(align_shift),
    .aligned(aligned), .comb_src(comb_src), .comb_mask(comb_mask),
    .comb_op(comb_op), .comb_inv(comb_inv),
    .busy(busy), .done(done), .err(err),
    .ev_reject(ev_reject), .ev_empty(ev_empty)
  );

  bitblt_align #(.W(W), .SW(SW)) u_align (
    .cur(align_cur), .carry(align_carry), .shift(align_shift), .aligned(aligned)
  );

  bitblt_combine #(.W(W)) u_comb (
    .op(comb_op), .inv(comb_inv), .src(comb_src), .dst(mem_rdata),
    .mask(comb_mask), .res(mem_wdata)
  );
endmodule

// File: rtl/bitblt_chk.sv
module bitblt_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic mem_req,
  input logic mem_we,
  input logic ev_reject,
  input logic ev_empty
);
  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r11_write_in_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && busy));

  a_r1_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r8_reject_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (done && err && !mem_req));

  a_r9_empty_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    ev_empty |=> (done && !err && !mem_req));
endmodule

bind bitblt_engine bitblt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .mem_req(mem_req), .mem_we(mem_we), .ev_reject(ev_reject), .ev_empty(ev_empty)
);

// File: tb/bitblt_engine_bench.sv
`timescale 1ns/1ps
module bitblt_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cfg_src_base = '0, cfg_dst_base = '0, cfg_src_pitch = '0, cfg_dst_pitch = '0;
  logic [3:0]  cfg_shift = '0;
  logic [7:0]  cfg_height = '0, cfg_width = '0;
  logic [15:0] cfg_mask_first = '0, cfg_mask_last = '0;
  logic [2:0]  cfg_op = '0;
  logic        cfg_desc = 1'b0, cfg_inv = 1'b0;
  logic        mem_req, mem_we, busy, done, err;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  logic [15:0] mem  [256];
  logic [15:0] snap [256];
  logic [15:0] refm [256];
  int          wr_count = 0;
  int          done_count = 0;
  logic [7:0]  first_wa = '0;

  always #4 clk = ~clk;

  bitblt_engine u_bitblt_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_src_pitch(cfg_src_pitch), .cfg_dst_pitch(cfg_dst_pitch),
    .cfg_shift(cfg_shift), .cfg_height(cfg_height), .cfg_width(cfg_width),
    .cfg_mask_first(cfg_mask_first), .cfg_mask_last(cfg_mask_last),
    .cfg_op(cfg_op), .cfg_desc(cfg_desc), .cfg_inv(cfg_inv),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .err(err)
  );

  // Synchronous memory: read data appears the cycle after the request.
  always @(posedge clk) begin
    if (done) done_count <= done_count + 1;
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        if (wr_count == 0) first_wa <= mem_addr[7:0];
        wr_count <= wr_count + 1;
      end else begin
        mem_rdata <= mem[mem_addr[7:0]];
      end
    end
  end

  // Vector: err[97] writes[96:89] op[88:86] desc[85] inv[84] sh[83:80]
  //         h[79:72] w[71:64] src[63:56] dst[55:48] sp[47:40] dp[39:32] mf[31:16] ml[15:0]
  localparam int NV = 14;
  localparam logic [97:0] VECS [NV] = '{
    {1'b0, 8'd6, 3'd3, 1'b0, 1'b0, 4'd0,  8'd2, 8'd3, 8'd16,  8'd64,  8'h08, 8'h08, 16'hFFFF, 16'hFFFF},
    {1'b0, 8'd6, 3'd0, 1'b0, 1'b0, 4'd5,  8'd3, 8'd2, 8'd32,  8'd96,  8'h04, 8'h10, 16'h0FFF, 16'hF000},
    {1'b0, 8'd4, 3'd1, 1'b0, 1'b0, 4'd15, 8'd1, 8'd4, 8'd40,  8'd120, 8'h00, 8'h00, 16'hFFFF, 16'hFFFF},
    {1'b0, 8'd6, 3'd2, 1'b1, 1'b1, 4'd3,  8'd2, 8'd3, 8'd48,  8'd140, 8'h08, 8'hF8, 16'hFF0F, 16'h00FF},
    {1'b0, 8'd4, 3'd4, 1'b0, 1'b0, 4'd7,  8'd2, 8'd2, 8'd60,  8'd170, 8'h02, 8'h05, 16'hFFFF, 16'h7FFF},
    {1'b0, 8'd4, 3'd3, 1'b1, 1'b0, 4'd0,  8'd1, 8'd4, 8'd200, 8'd201, 8'h00, 8'h00, 16'hFFFF, 16'hFFFF},
    {1'b0, 8'd2, 3'd3, 1'b0, 1'b0, 4'd4,  8'd2, 8'd1, 8'd10,  8'd230, 8'h01, 8'h01, 16'h00FF, 16'h0FF0},
    {1'b0, 8'd6, 3'd0, 1'b0, 1'b1, 4'd9,  8'd3, 8'd2, 8'd220, 8'd80,  8'hEC, 8'h03, 16'hFFFF, 16'hFFFF},
    {1'b1, 8'd0, 3'd4, 1'b1, 1'b0, 4'd0,  8'd2, 8'd2, 8'd16,  8'd64,  8'h08, 8'h08, 16'hFFFF, 16'hFFFF},
    {1'b1, 8'd0, 3'd4, 1'b0, 1'b1, 4'd0,  8'd2, 8'd2, 8'd16,  8'd64,  8'h08, 8'h08, 16'hFFFF, 16'hFFFF},
    {1'b1, 8'd0, 3'd6, 1'b0, 1'b0, 4'd0,  8'd2, 8'd2, 8'd16,  8'd64,  8'h08, 8'h08, 16'hFFFF, 16'hFFFF},
    {1'b0, 8'd0, 3'd3, 1'b0, 1'b0, 4'd0,  8'd0, 8'd2, 8'd16,  8'd64,  8'h08, 8'h08, 16'hFFFF, 16'hFFFF},
    {1'b0, 8'd0, 3'd3, 1'b0, 1'b0, 4'd0,  8'd2, 8'd0, 8'd16,  8'd64,  8'h08, 8'h08, 16'hFFFF, 16'hFFFF},
    {1'b0, 8'd3, 3'd3, 1'b1, 1'b0, 4'd4,  8'd1, 8'd3, 8'd100, 8'd101, 8'h00, 8'h00, 16'hFFFF, 16'hFFFF}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill_mem(input int seed);
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 16'(i * 40503 + seed * 977) ^ 16'hA5C3;
      snap[i] = mem[i];
      refm[i] = mem[i];
    end
  endtask

  // Reference image built from the snapshot, word by word, per requirement.
  task automatic model(input logic [97:0] v);
    logic [7:0]  sl, dl;
    logic [15:0] cur, prev, al, d, f, m;
    if (v[97] || v[79:72] == 0 || v[71:64] == 0) return;
    sl = v[63:56];
    dl = v[55:48];
    for (int y = 0; y < int'(v[79:72]); y++) begin
      for (int k = 0; k < int'(v[71:64]); k++) begin
        cur  = snap[8'(sl + 8'(k))];
        prev = (k == 0) ? 16'h0 : snap[8'(sl + 8'(k) - 8'd1)];
        al   = (cur << v[83:80]) | ((v[83:80] == 0) ? 16'h0 : (prev >> (16 - int'(v[83:80]))));
        if (v[84]) al = ~al;
        d = refm[8'(dl + 8'(k))];
        case (v[88:86])
          3'd0: f = al & d;
          3'd2: f = al ^ d;
          3'd3: f = al;
          default: f = al | d;
        endcase
        m = 16'hFFFF;
        if (k == 0) m = m & v[31:16];
        if (k == int'(v[71:64]) - 1) m = m & v[15:0];
        refm[8'(dl + 8'(k))] = (f & m) | (d & ~m);
      end
      sl = sl + v[47:40];
      dl = dl + v[39:32];
    end
  endtask

  task automatic drive_cfg(input logic [97:0] v);
    cfg_op         = v[88:86];
    cfg_desc       = v[85];
    cfg_inv        = v[84];
    cfg_shift      = v[83:80];
    cfg_height     = v[79:72];
    cfg_width      = v[71:64];
    cfg_src_base   = {8'h00, v[63:56]};
    cfg_dst_base   = {8'h00, v[55:48]};
    cfg_src_pitch  = {{8{v[47]}}, v[47:40]};
    cfg_dst_pitch  = {{8{v[39]}}, v[39:32]};
    cfg_mask_first = v[31:16];
    cfg_mask_last  = v[15:0];
  endtask

  task automatic wait_done(output bit seen, output bit err_seen);
    int n;
    n = 0;
    seen = 0;
    err_seen = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (done) begin
      seen = 1;
      err_seen = err;
    end
  endtask

  task automatic compare_image(input string req, output int bad);
    int first_bad;
    bad = 0;
    first_bad = -1;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== refm[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    if (first_bad < 0) check(1'b1, req, "image", 0, 0);
    else check(1'b0, req, $sformatf("image word %0d", first_bad),
               int'(mem[first_bad]), int'(refm[first_bad]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit seen, es;
    int bad;
    logic [97:0] v;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(!busy && !done && !err && !mem_req, "R1", "idle outputs after reset",
          {busy, done, err, mem_req}, 0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      fill_mem(i);
      model(v);
      @(negedge clk);
      wr_count = 0;
      drive_cfg(v);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(seen, es);
      check(seen && (es == v[97]), v[97] ? "R8" : "R9/R10",
            $sformatf("vec %0d done/err", i), {seen, es}, {1'b1, v[97]});
      @(negedge clk);
      check(!done, "R10", $sformatf("vec %0d done single cycle", i), done, 0);
      check(wr_count == int'(v[96:89]), (v[96:89] == 0) ? "R9" : "R11",
            $sformatf("vec %0d write count", i), wr_count, int'(v[96:89]));
      compare_image("R2/R3/R4/R5/R6/R7", bad);
      if (v[96:89] != 0)
        check(first_wa == (v[85] ? 8'(v[55:48] + v[71:64] - 8'd1) : v[55:48]), "R6",
              $sformatf("vec %0d first write address", i), int'(first_wa),
              int'(v[85] ? 8'(v[55:48] + v[71:64] - 8'd1) : v[55:48]));
    end

    // R10: a second start while busy is ignored
    v = VECS[0];
    fill_mem(99);
    model(v);
    @(negedge clk);
    wr_count = 0;
    done_count = 0;
    drive_cfg(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy, "R10", "busy during transfer", busy, 1);
    cfg_op = 3'd2;
    cfg_dst_base = 16'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen, es);
    repeat (40) @(negedge clk);
    check(done_count == 1, "R10", "one done for start while busy", done_count, 1);
    check(wr_count == 6, "R10", "writes unchanged by start while busy", wr_count, 6);
    compare_image("R10", bad);
    check(!busy && !mem_req, "R1", "idle after run", {busy, mem_req}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule